// File: doc/BRIEF.md
# Wiper Preset Store Controller

This block keeps the nonvolatile copies of two 10-bit wiper settings and a small general-purpose byte store, modelled as one register array. It owns the two live wiper registers. It serves requests from a serial command decoder: set a wiper directly, save a wiper into its stored copy, write a user byte, recall a stored copy into a wiper, and read back any stored entry. Every slow operation is timed by a cycle counter. An active-high ready output is low while the counter runs.

The live wipers are also refreshed from their stored copies in two other ways. The first is an automatic load in the first cycle after reset. The second is a falling edge on an active-low preset pin, which is synchronised to the clock inside the block. An active-low write-protect input blocks every change to the store. A blocked request ends at once and leaves a sticky flag set. The operation lengths are parameters in clock cycles, so a simulation can use short values.

Top module: `preset_store_ctrl`

## Requirements
- R1: After reset both stored wiper copies (slots 0 and 1) hold 512, user slots 2 to 31 hold 0, `blocked` is 0 and `ready` is 0.
- R2: In the first clock edge after reset is released, both wipers are loaded from their stored copies and `ready` rises. No request is acknowledged before that edge.
- R3: Op code 0 sets wiper `req_addr[0]` to `req_data` in the acknowledging edge, with no busy period.
- R4: Op code 1 saves wiper `req_addr[0]`, as it stood at acceptance, into stored slot `req_addr[0]`. `ready` is low for exactly `T_SAVE` cycles after acceptance.
- R5: Op code 2 writes `req_data[7:0]`, zero-extended, into user slot `req_addr` (2 to 31), with `ready` low for `T_SAVE` cycles. For addresses 0 and 1 it is acknowledged with no effect and no busy period.
- R6: Op code 3 loads wiper `req_addr[0]` from its stored copy. `ready` is low for `T_RECALL` cycles.
- R7: Op code 4 places stored entry `req_addr` on `rd_data` (user bytes zero-extended). `ready` is low for `T_READ` cycles.
- R8: While `wp_n` is 0 at acceptance, op 1, and op 2 to a user slot, are acknowledged with no busy period and no change to the store. `blocked` goes high and stays high until reset.
- R9: A falling edge on `preset_n` (held low for at least two clocks) reloads both wipers from their stored copies at the third clock edge. This also happens during a busy period, and does not alter the timed operation.
- R10: In the cycle a preset event is applied, no request is acknowledged. A held request is taken in a later cycle.
- R11: `busy` is high in the same cycle a timed operation is acknowledged and for the whole time `ready` is low. `req_ack` is never high while an operation is running.
- R12: Op codes 5 to 7 are acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, stands for power-up |
| wp_n | input | 1 | Active-low write protect for the store |
| preset_n | input | 1 | Asynchronous active-low preset pin |
| req_valid | input | 1 | Request pending from the decoder, held until acknowledged |
| req_op | input | 3 | Operation code |
| req_addr | input | 5 | Slot or wiper address |
| req_data | input | 10 | Wiper value or user byte |
| req_ack | output | 1 | Request taken this cycle |
| busy | output | 1 | Decoder must not start a new frame |
| ready | output | 1 | High when no operation is in progress |
| blocked | output | 1 | Sticky write-protect violation flag |
| rd_data | output | 10 | Result of the last read-back |
| wiper0 | output | 10 | Live setting of wiper 0 |
| wiper1 | output | 10 | Live setting of wiper 1 |

## Verification
The preset event can coincide with two other activities.

The first is a request arriving in the same cycle. The bench provokes this by pulling the pin low and raising a direct-set request exactly two clocks later. It then expects no acknowledge in that cycle, an acknowledge one cycle later, and a final wiper holding the request data.

The second is a save whose busy period is still running. The bench expects the wiper to fall back to the old stored value, and the store to receive the value captured at acceptance, which it confirms through a read-back.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam logic [2:0] OP_WSET   = 3'd0;
  localparam logic [2:0] OP_SAVE   = 3'd1;
  localparam logic [2:0] OP_UWRITE = 3'd2;
  localparam logic [2:0] OP_RECALL = 3'd3;
  localparam logic [2:0] OP_READ   = 3'd4;

  // slots 0 and 1 hold wiper copies, user bytes follow
  function automatic logic is_user_slot(input int a, input int n_user);
    return (a >= 2) && (a < n_user + 2);
  endfunction

  function automatic int op_cycles(input logic [2:0] op, input int t_save,
                                   input int t_recall, input int t_read);
    case (op)
      OP_SAVE, OP_UWRITE: return t_save;
      OP_RECALL:          return t_recall;
      OP_READ:            return t_read;
      default:            return 0;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psc_pin_sync.sv
module psc_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_evt
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= pin_n;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign fall_evt = prev & ~s2;

  a_r9_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/psc_op_timer.sv
module psc_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= load_val;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);

  a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !run);
  a_r4_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |=> run);
  a_r4_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !run);

endmodule

// File: rtl/psc_nv_array.sv
module psc_nv_array #(
  parameter int W       = 10,
  parameter int BYTE_W  = 8,
  parameter int DEPTH   = 32,
  parameter int AW      = 5,
  parameter int MID     = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  slot0,
  output logic [W-1:0]  slot1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < 2) ? W'(MID) : '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
  assign slot0 = mem[0];
  assign slot1 = mem[1];

  a_r5_user_byte_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr >= AW'(2)) |-> (wdata >> BYTE_W) == '0);

endmodule

// File: rtl/preset_store_ctrl.sv
module preset_store_ctrl
  import psc_pkg::*;
#(
  parameter int WIPER_W  = 10,
  parameter int UBYTE_W  = 8,
  parameter int N_USER   = 30,
  parameter int T_SAVE   = 1000000,
  parameter int T_RECALL = 50000,
  parameter int T_READ   = 5000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_n,
  input  logic               preset_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [4:0]         req_addr,
  input  logic [WIPER_W-1:0] req_data,
  output logic               req_ack,
  output logic               busy,
  output logic               ready,
  output logic               blocked,
  output logic [WIPER_W-1:0] rd_data,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);
  localparam int DEPTH  = N_USER + 2;
  localparam int ADDR_W = 5;
  localparam int MID    = 1 << (WIPER_W - 1);
  localparam int CNT_W  = $clog2(max3(T_SAVE, T_RECALL, T_READ) + 1);

  // named internal events
  logic preset_evt, accept, user_ok, wp_hit, start_timed, wset_hit;
  logic run, done, c_save, c_uwr, c_rec, c_rd;
  logic boot;
  logic [2:0]         cur_op;
  logic [ADDR_W-1:0]  cur_addr;
  logic [WIPER_W-1:0] cur_data, cap_data;
  logic               we;
  logic [ADDR_W-1:0]  waddr;
  logic [WIPER_W-1:0] rdata, slot0, slot1;
  logic [CNT_W-1:0]   load_val;

  psc_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(preset_n), .fall_evt(preset_evt)
  );

  assign user_ok     = is_user_slot(int'(req_addr), N_USER);
  assign accept      = req_valid & ~boot & ~run & ~preset_evt;
  assign wp_hit      = accept & ~wp_n &
                       ((req_op == OP_SAVE) | ((req_op == OP_UWRITE) & user_ok));
  assign start_timed = accept & ~wp_hit &
                       ((req_op == OP_SAVE) | (req_op == OP_RECALL) |
                        (req_op == OP_READ) | ((req_op == OP_UWRITE) & user_ok));
  assign wset_hit    = accept & (req_op == OP_WSET);
  assign load_val    = CNT_W'(op_cycles(req_op, T_SAVE, T_RECALL, T_READ) - 1);

  psc_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start_timed), .load_val(load_val),
    .run(run), .done(done)
  );

  // value captured at acceptance: wiper for a save, clean byte otherwise
  assign cap_data = (req_op == OP_SAVE) ? (req_addr[0] ? wiper1 : wiper0)
                                        : WIPER_W'(req_data[UBYTE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op   <= OP_WSET;
      cur_addr <= '0;
      cur_data <= '0;
    end else if (start_timed) begin
      cur_op   <= req_op;
      cur_addr <= req_addr;
      cur_data <= cap_data;
    end
  end

  assign c_save = done & (cur_op == OP_SAVE);
  assign c_uwr  = done & (cur_op == OP_UWRITE);
  assign c_rec  = done & (cur_op == OP_RECALL);
  assign c_rd   = done & (cur_op == OP_READ);

  assign we    = c_save | c_uwr;
  assign waddr = c_save ? ADDR_W'(cur_addr[0]) : cur_addr;

  psc_nv_array #(
    .W(WIPER_W), .BYTE_W(UBYTE_W), .DEPTH(DEPTH), .AW(ADDR_W), .MID(MID)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(cur_data),
    .raddr(cur_addr), .rdata(rdata), .slot0(slot0), .slot1(slot1)
  );

  // live wipers: boot > preset > recall > direct set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot   <= 1'b1;
      wiper0 <= '0;
      wiper1 <= '0;
    end else begin
      boot <= 1'b0;
      if (boot || preset_evt) begin
        wiper0 <= slot0;
        wiper1 <= slot1;
      end else if (c_rec) begin
        if (cur_addr[0]) wiper1 <= slot1;
        else             wiper0 <= slot0;
      end else if (wset_hit) begin
        if (req_addr[0]) wiper1 <= req_data;
        else             wiper0 <= req_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wp_hit) blocked <= 1'b1;
      if (c_rd)   rd_data <= rdata;
    end
  end

  assign req_ack = accept;
  assign ready   = ~boot & ~run;
  assign busy    = boot | run | start_timed;

  a_r2_boot_loads: assert property (@(posedge clk) disable iff (!rst_n)
    boot |=> (wiper0 == $past(slot0)) && (wiper1 == $past(slot1)));
  a_r8_blocked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> blocked);
  a_r8_block_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |=> ready && $stable(slot0) && $stable(slot1));
  a_r10_preset_first: assert property (@(posedge clk) disable iff (!rst_n)
    preset_evt |-> !req_ack);
  a_r11_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_timed |-> busy);
  a_r11_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> busy && !req_ack);
  a_r9_preset_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_evt && !boot) |=> (wiper0 == $past(slot0)) && (wiper1 == $past(slot1)));

endmodule

// File: tb/sim_preset_store_ctrl.sv
module sim_preset_store_ctrl;
  localparam int TS = 20, TR = 8, TD = 3;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1, preset_n = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [4:0] req_addr = '0;
  logic [9:0] req_data = '0;
  logic req_ack, busy, ready, blocked;
  logic [9:0] rd_data, wiper0, wiper1;

  int total = 0, bad = 0;
  int m_st[32];
  int m_w[2];
  bit m_blk;

  always #10 clk = ~clk;

  preset_store_ctrl #(.T_SAVE(TS), .T_RECALL(TR), .T_READ(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .preset_n(preset_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_ack(req_ack), .busy(busy), .ready(ready),
    .blocked(blocked), .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_st[i] = (i < 2) ? 512 : 0;
    m_w[0] = 512; m_w[1] = 512; m_blk = 0;
  endtask

  task automatic issue(input int op, input int addr, input int data,
                       output int low, output bit busy_seen);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = 5'(addr); req_data = 10'(data);
    #1;
    while (!req_ack) begin @(negedge clk); #1; end
    busy_seen = busy;
    @(negedge clk);
    req_valid = 1'b0;
    low = 0;
    while (!ready) begin low++; @(negedge clk); end
  endtask

  task automatic do_op(input int op, input int addr, input int data);
    int exp_low, low, exp_rd;
    bit bs;
    string t;
    t = op_tag(op);
    exp_low = 0; exp_rd = -1;
    case (op)
      0: m_w[addr & 1] = data;
      1: if (!wp_n) m_blk = 1;
         else begin m_st[addr & 1] = m_w[addr & 1]; exp_low = TS; end
      2: if (addr >= 2) begin
           if (!wp_n) m_blk = 1;
           else begin m_st[addr] = data & 255; exp_low = TS; end
         end
      3: begin m_w[addr & 1] = m_st[addr & 1]; exp_low = TR; end
      4: begin exp_rd = m_st[addr]; exp_low = TD; end
      default: ;
    endcase
    issue(op, addr, data, low, bs);
    chk(low == exp_low, t, low, exp_low);
    chk(bs == (exp_low != 0), "R11", bs, exp_low != 0);
    chk(wiper0 == m_w[0] && wiper1 == m_w[1], t, wiper0 * 1024 + wiper1,
        m_w[0] * 1024 + m_w[1]);
    chk(blocked == m_blk, "R8", blocked, m_blk);
    if (exp_rd >= 0) chk(rd_data == exp_rd, "R7", rd_data, exp_rd);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; model_reset();
    repeat (2) @(negedge clk);
    chk(ready == 1'b0, "R1", ready, 0);
    chk(blocked == 1'b0, "R1", blocked, 0);
    rst_n = 1'b1;
    req_valid = 1'b1; req_op = 3'd0; req_addr = 5'd0; req_data = 10'd77;
    #1 chk(req_ack == 1'b0, "R2", req_ack, 0);
    chk(ready == 1'b0, "R2", ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(wiper0 == 512 && wiper1 == 512, "R2", wiper0, 512);
    chk(ready == 1'b1, "R2", ready, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int op, a, d;
    void'($urandom(32'h5eed));
    do_reset();
    // R1 reset contents via read-back
    do_op(4, 0, 0);
    do_op(4, 1, 0);
    do_op(4, 17, 0);
    // directed functions
    do_op(0, 0, 100);
    do_op(1, 0, 0);
    do_op(4, 0, 0);
    do_op(2, 31, 10'h3AB);
    do_op(4, 31, 0);
    do_op(2, 1, 10'h3FF);          // R5 ignored low address
    do_op(4, 1, 0);
    wp_n = 1'b0;
    do_op(0, 1, 900);
    do_op(1, 1, 0);                // R8 blocked save
    do_op(2, 5, 10'h55);           // R8 blocked user write
    do_op(4, 1, 0);
    do_op(4, 5, 0);
    wp_n = 1'b1;
    do_op(3, 1, 0);
    do_op(6, 3, 1);                // R12 spare code
    // R9 plain preset
    do_op(0, 0, 7);
    do_op(0, 1, 9);
    @(negedge clk) preset_n = 1'b0;
    repeat (3) @(negedge clk);
    preset_n = 1'b1;
    repeat (3) @(negedge clk);
    m_w[0] = m_st[0]; m_w[1] = m_st[1];
    chk(wiper0 == m_w[0] && wiper1 == m_w[1], "R9", wiper0 * 1024 + wiper1,
        m_w[0] * 1024 + m_w[1]);
    // R9 preset during a save busy period
    do_op(0, 1, 333);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 5'd1; req_data = '0;
    #1 chk(req_ack == 1'b1, "R4", req_ack, 1);
    @(negedge clk);
    req_valid = 1'b0; preset_n = 1'b0;
    repeat (3) @(negedge clk);
    preset_n = 1'b1;
    m_w[1] = m_st[1]; m_st[1] = 333;
    chk(ready == 1'b0, "R9", ready, 0);
    chk(wiper1 == m_w[1], "R9", wiper1, m_w[1]);
    while (!ready) @(negedge clk);
    do_op(4, 1, 0);
    // R10 preset event meets a held request
    @(negedge clk) preset_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_addr = 5'd0; req_data = 10'd55;
    #1 chk(req_ack == 1'b0, "R10", req_ack, 0);
    @(negedge clk);
    #1 chk(req_ack == 1'b1, "R10", req_ack, 1);
    @(negedge clk);
    req_valid = 1'b0;
    m_w[0] = 55; m_w[1] = m_st[1];
    chk(wiper0 == 55 && wiper1 == m_w[1], "R10", wiper0 * 1024 + wiper1,
        55 * 1024 + m_w[1]);
    preset_n = 1'b1;
    repeat (3) @(negedge clk);
    // constrained random mix
    for (int k = 0; k < 80; k++) begin
      op = $urandom_range(0, 5);
      if (op == 5) op = $urandom_range(5, 7);
      a = $urandom_range(0, 31);
      d = $urandom_range(0, 1023);
      @(negedge clk) wp_n = ($urandom_range(0, 3) != 0);
      do_op(op, a, d);
    end
    wp_n = 1'b1;
    // R8 flag clears only on reset
    do_reset();
    chk(blocked == 1'b0, "R8", blocked, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule